// File: doc/BRIEF.md
# Glitch-Free Clock Stop Gate

This block sits after the dividers of a clock generator and decides, lane by lane, whether a generated clock reaches its output. It serves two groups. The processor group carries differential lanes (a true line, a complement line and a drive enable that models high impedance). The bus group carries single-ended lanes that park low. Each group has its own active-low stop input. The stop is qualified per lane by a stoppable bit, and every lane also has an enable bit. Everything runs on one fast core clock. The divided source clocks arrive as level inputs that change between core clock edges.

A stop request is captured by a two-stage chain that advances only on rising edges of the group's own source clock. A lane's run state is then updated only in a core cycle where its source is low. A lane therefore always stops after a complete high phase and restarts with a complete one. The latency from request to effect is bounded in whole source periods.

In the bus group, the lowest lanes are the free-running ones, and their stoppable bits are inputs. All other bus lanes are always stoppable. The processor group takes one stoppable bit per lane.

Top module: `clkstop_gate`

## Requirements
- R1: While `cpu_stop_n` is held low, every processor lane whose `cpu_stop_mask[i]` is 1 stops. The stop takes effect only after the low request has been seen on two successive rising edges of `cpu_src`, and it lands at the first low phase after that. Measured in core cycles from the request, it is no earlier than 5 and no later than 12 when `cpu_src` has a period of 4 core cycles.
- R2: A stopped processor lane has `cpu_oe[i]` = 0 (both lines released), and `cpu_t[i]` and `cpu_c[i]` stay low.
- R3: After `cpu_stop_n` returns high, a stopped processor lane drives again within the same 5 to 12 cycle window. Every high phase of `cpu_t` lasts exactly one full high phase of `cpu_src`.
- R4: A processor lane with `cpu_stop_mask[i]` = 0 keeps toggling and stays driven while the stop is held.
- R5: While `pci_stop_n` is low, bus lanes numbered `N_FREE` and above always stop. A lower lane j stops only when `pci_free_stop[j]` = 1, and keeps running when that bit is 0.
- R6: A stopped bus lane parks low. Every high phase on `pci_clk` lasts exactly one full high phase of `pci_src`, so no pulse is shortened or lengthened.
- R7: After `pci_stop_n` returns high, the first complete high phase of a stopped bus lane begins 9 to 25 core cycles later when `pci_src` has a period of 8 core cycles.
- R8: A lane whose enable bit (`cpu_en[i]` or `pci_en[j]`) is 0 is off (bus lane low, processor lane released), whatever the stop inputs do. The change takes effect at the lane's next low phase, and the other lanes are unaffected.
- R9: During reset every bus lane is low and every processor lane is released. After reset, enabled lanes start at their first low phase.
- R10: While a processor lane is driven, its true and complement lines are always opposite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_src | input | 1 | Divided processor source clock (level, core-clock synchronous) |
| pci_src | input | 1 | Divided bus source clock (level, core-clock synchronous) |
| cpu_stop_n | input | 1 | Active-low stop request, processor group |
| pci_stop_n | input | 1 | Active-low stop request, bus group |
| cpu_stop_mask | input | N_CPU | 1 = processor lane i obeys the stop |
| cpu_en | input | N_CPU | 1 = processor lane i enabled |
| pci_free_stop | input | N_FREE | 1 = free bus lane j obeys the stop, 0 = keeps running |
| pci_en | input | N_PCI | 1 = bus lane j enabled |
| cpu_t | output | N_CPU | True line of each processor lane |
| cpu_c | output | N_CPU | Complement line of each processor lane |
| cpu_oe | output | N_CPU | Drive enable of each processor lane (0 = high impedance) |
| pci_clk | output | N_PCI | Gated bus clocks |

## Verification
The gate is tried with a stop on a processor group that mixes stoppable and free lanes, and then with every processor lane stoppable. Latency is measured in both directions against the two-edge capture window. On the bus group, the free-lane bits are set first to one run and one stop and then to both stop. This separates the fixed lanes from the qualified ones. Enable bits are cleared with the stop both idle and held, which shows that disable wins over the stop qualification. A running monitor measures every high phase on each gated output, so any runt or stretched pulse at a stop or restart boundary shows up.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  localparam int CPU_LANES      = 2;
  localparam int PCI_LANES      = 8;
  localparam int PCI_FREE_LANES = 2;
  localparam int SYNC_DEPTH     = 2;
  localparam int RST_DEPTH      = 2;
endpackage

// File: rtl/clkstop_rst_sync.sv
module clkstop_rst_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [DEPTH-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[DEPTH-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[DEPTH-1];
endmodule

// File: rtl/clkstop_req_sync.sv
module clkstop_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic stop_n,
  output logic stop_q
);
  logic              src_d;
  logic              src_rise;
  logic [STAGES-1:0] chain_q, chain_d;

  // advance the capture chain only on rising edges of the group source
  always_comb begin
    src_rise = src & ~src_d;
    chain_d  = chain_q;
    if (src_rise) chain_d = {chain_q[STAGES-2:0], ~stop_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_d   <= 1'b0;
      chain_q <= '0;
    end else begin
      src_d   <= src;
      chain_q <= chain_d;
    end
  end

  assign stop_q = chain_q[STAGES-1];
endmodule

// File: rtl/clkstop_lane.sv
module clkstop_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic stop_q,
  input  logic stoppable,
  input  logic en,
  output logic run,
  output logic gclk
);
  logic upd_en;
  logic run_d;

  // the run state may only move while the source is low
  always_comb begin
    upd_en = ~src;
    run_d  = en & ~(stop_q & stoppable);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run <= 1'b0;
    else if (upd_en) run <= run_d;
  end

  assign gclk = src & run;
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate
  import clkstop_pkg::*;
#(
  parameter int N_CPU       = CPU_LANES,
  parameter int N_PCI       = PCI_LANES,
  parameter int N_FREE      = PCI_FREE_LANES,
  parameter int SYNC_STAGES = SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_src,
  input  logic              pci_src,
  input  logic              cpu_stop_n,
  input  logic              pci_stop_n,
  input  logic [N_CPU-1:0]  cpu_stop_mask,
  input  logic [N_CPU-1:0]  cpu_en,
  input  logic [N_FREE-1:0] pci_free_stop,
  input  logic [N_PCI-1:0]  pci_en,
  output logic [N_CPU-1:0]  cpu_t,
  output logic [N_CPU-1:0]  cpu_c,
  output logic [N_CPU-1:0]  cpu_oe,
  output logic [N_PCI-1:0]  pci_clk
);
  localparam int N_FIXED = N_PCI - N_FREE;

  logic             rst_i_n;
  logic             cpu_stop_q;
  logic             pci_stop_q;
  logic [N_CPU-1:0] cpu_run;
  logic [N_PCI-1:0] pci_run;
  logic [N_PCI-1:0] pci_stoppable;

  clkstop_rst_sync #(.DEPTH(RST_DEPTH)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  clkstop_req_sync #(.STAGES(SYNC_STAGES)) u_cpu_sync (
    .clk(clk), .rst_n(rst_i_n), .src(cpu_src), .stop_n(cpu_stop_n), .stop_q(cpu_stop_q)
  );

  clkstop_req_sync #(.STAGES(SYNC_STAGES)) u_pci_sync (
    .clk(clk), .rst_n(rst_i_n), .src(pci_src), .stop_n(pci_stop_n), .stop_q(pci_stop_q)
  );

  // low bus lanes are qualified by a bit, the rest always obey the stop
  generate
    if (N_FIXED > 0) begin : g_fixed
      assign pci_stoppable = {{N_FIXED{1'b1}}, pci_free_stop};
    end else begin : g_allfree
      assign pci_stoppable = pci_free_stop;
    end
  endgenerate

  generate
    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
      clkstop_lane u_lane (
        .clk(clk), .rst_n(rst_i_n), .src(cpu_src), .stop_q(cpu_stop_q),
        .stoppable(cpu_stop_mask[i]), .en(cpu_en[i]),
        .run(cpu_run[i]), .gclk(cpu_t[i])
      );
      // released pair: both lines low and drive enable off
      assign cpu_c[i]  = ~cpu_src & cpu_run[i];
      assign cpu_oe[i] = cpu_run[i];
    end

    for (genvar j = 0; j < N_PCI; j++) begin : g_pci
      clkstop_lane u_lane (
        .clk(clk), .rst_n(rst_i_n), .src(pci_src), .stop_q(pci_stop_q),
        .stoppable(pci_stoppable[j]), .en(pci_en[j]),
        .run(pci_run[j]), .gclk(pci_clk[j])
      );
    end
  endgenerate
endmodule

// File: rtl/clkstop_gate_chk.sv
module clkstop_gate_chk #(
  parameter int N_CPU = 2,
  parameter int N_PCI = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_src,
  input logic             pci_src,
  input logic [N_CPU-1:0] cpu_en,
  input logic [N_CPU-1:0] cpu_stop_mask,
  input logic             cpu_stop_q,
  input logic [N_PCI-1:0] pci_en,
  input logic [N_CPU-1:0] cpu_t,
  input logic [N_CPU-1:0] cpu_c,
  input logic [N_CPU-1:0] cpu_oe,
  input logic [N_PCI-1:0] pci_run,
  input logic [N_PCI-1:0] pci_stoppable,
  input logic             pci_stop_q
);
  // R3: processor drive state only moves in a cycle where the source was low
  p_cpu_edge_safe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cpu_oe) |-> !$past(cpu_src));

  // R6: bus run state only moves in a cycle where the source was low
  p_pci_edge_safe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pci_run) |-> !$past(pci_src));

  // R10: driven pair lines are opposite, released pair lines are low
  p_cpu_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_t ^ cpu_c) == cpu_oe);

  // R4: a processor lane drops only when disabled or qualified by the stop
  p_cpu_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (~cpu_oe & $past(cpu_oe) & $past(cpu_en)
     & ~($past(cpu_stop_mask) & {N_CPU{$past(cpu_stop_q)}})) == '0);

  // R5: a bus lane drops only when disabled or qualified by the stop
  p_pci_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (~pci_run & $past(pci_run) & $past(pci_en)
     & ~($past(pci_stoppable) & {N_PCI{$past(pci_stop_q)}})) == '0);

  // R8: a disabled lane never turns on
  p_cpu_dis_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_oe & ~$past(cpu_oe) & ~$past(cpu_en)) == '0);

  p_pci_dis_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_run & ~$past(pci_run) & ~$past(pci_en)) == '0);
endmodule

bind clkstop_gate clkstop_gate_chk #(.N_CPU(N_CPU), .N_PCI(N_PCI)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_src(cpu_src), .pci_src(pci_src),
  .cpu_en(cpu_en), .cpu_stop_mask(cpu_stop_mask), .cpu_stop_q(cpu_stop_q),
  .pci_en(pci_en), .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_oe(cpu_oe),
  .pci_run(pci_run), .pci_stoppable(pci_stoppable), .pci_stop_q(pci_stop_q)
);

// File: tb/tb_clkstop_gate.sv
module tb_clkstop_gate;
  localparam int N_CPU    = 2;
  localparam int N_PCI    = 8;
  localparam int N_FREE   = 2;
  localparam int CPU_HALF = 2;
  localparam int PCI_HALF = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_src = 1'b0, pci_src = 1'b0;
  logic cpu_stop_n, pci_stop_n;
  logic [N_CPU-1:0]  cpu_stop_mask, cpu_en;
  logic [N_FREE-1:0] pci_free_stop;
  logic [N_PCI-1:0]  pci_en;
  logic [N_CPU-1:0]  cpu_t, cpu_c, cpu_oe;
  logic [N_PCI-1:0]  pci_clk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  int cpu_cnt = 0, pci_cnt = 0;

  int pci_rise [N_PCI];
  int cpu_rise [N_CPU];
  bit cpu_oe_low_all [N_CPU];
  logic [N_PCI-1:0] pci_hi_seen;
  int pci_hl [N_PCI];
  int cpu_hl [N_CPU];

  clkstop_gate #(.N_CPU(N_CPU), .N_PCI(N_PCI), .N_FREE(N_FREE)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_src(cpu_src), .pci_src(pci_src),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
    .cpu_stop_mask(cpu_stop_mask), .cpu_en(cpu_en),
    .pci_free_stop(pci_free_stop), .pci_en(pci_en),
    .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_oe(cpu_oe), .pci_clk(pci_clk)
  );

  always #4 clk = ~clk;

  // source clocks change between core edges
  always @(negedge clk) begin
    if (cpu_cnt == CPU_HALF - 1) begin cpu_cnt <= 0; cpu_src <= ~cpu_src; end
    else cpu_cnt <= cpu_cnt + 1;
    if (pci_cnt == PCI_HALF - 1) begin pci_cnt <= 0; pci_src <= ~pci_src; end
    else pci_cnt <= pci_cnt + 1;
  end

  // pulse-width and pair monitor (R3, R6, R10)
  always @(posedge clk) begin
    #2;
    if (!rst_n) begin
      for (int j = 0; j < N_PCI; j++) pci_hl[j] = 0;
      for (int i = 0; i < N_CPU; i++) cpu_hl[i] = 0;
    end else begin
      for (int j = 0; j < N_PCI; j++) begin
        if (pci_clk[j]) pci_hl[j]++;
        else if (pci_hl[j] != 0) begin
          checks++;
          if (pci_hl[j] != PCI_HALF) begin
            errors++;
            $display("FAIL R6 bus lane %0d high phase: actual %0d expected %0d", j, pci_hl[j], PCI_HALF);
          end
          pci_hl[j] = 0;
        end
      end
      for (int i = 0; i < N_CPU; i++) begin
        if (cpu_t[i]) cpu_hl[i]++;
        else if (cpu_hl[i] != 0) begin
          checks++;
          if (cpu_hl[i] != CPU_HALF) begin
            errors++;
            $display("FAIL R3 cpu lane %0d high phase: actual %0d expected %0d", i, cpu_hl[i], CPU_HALF);
          end
          cpu_hl[i] = 0;
        end
        if (cpu_oe[i]) begin
          checks++;
          if (cpu_t[i] == cpu_c[i]) begin
            errors++;
            $display("FAIL R10 cpu lane %0d pair: actual t=%0b c=%0b expected opposite", i, cpu_t[i], cpu_c[i]);
          end
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input string what, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic window(input int n);
    logic [N_PCI-1:0] pp;
    logic [N_CPU-1:0] cp;
    pp = pci_clk;
    cp = cpu_t;
    pci_hi_seen = '0;
    for (int j = 0; j < N_PCI; j++) pci_rise[j] = 0;
    for (int i = 0; i < N_CPU; i++) begin cpu_rise[i] = 0; cpu_oe_low_all[i] = 1; end
    for (int k = 0; k < n; k++) begin
      step();
      pci_hi_seen = pci_hi_seen | pci_clk;
      for (int j = 0; j < N_PCI; j++) if (pci_clk[j] && !pp[j]) pci_rise[j]++;
      for (int i = 0; i < N_CPU; i++) begin
        if (cpu_t[i] && !cp[i]) cpu_rise[i]++;
        if (cpu_oe[i]) cpu_oe_low_all[i] = 0;
      end
      pp = pci_clk;
      cp = cpu_t;
    end
  endtask

  task automatic wait_oe(input int lane, input logic val, output int n);
    n = 0;
    do begin step(); n++; end while (cpu_oe[lane] !== val && n < 100);
  endtask

  task automatic wait_pci_rise(input int lane, output int n);
    logic prev;
    n = 0;
    prev = pci_clk[lane];
    forever begin
      step();
      n++;
      if ((pci_clk[lane] && !prev) || n >= 100) break;
      prev = pci_clk[lane];
    end
  endtask

  task automatic t_reset();
    idle(3);
    chk("R9", "cpu_oe in reset", int'(cpu_oe), 0);
    chk("R9", "pci_clk in reset", int'(pci_clk), 0);
    @(negedge clk) rst_n = 1'b1;
    idle(12);
    chk("R9", "cpu_oe after reset", int'(cpu_oe), 3);
    window(16);
    chk("R9", "bus lane 5 rises after reset", pci_rise[5], 2);
  endtask

  task automatic t_cpu_stop();
    int n;
    @(negedge clk) cpu_stop_n = 1'b0;
    wait_oe(0, 1'b0, n);
    chk_rng("R1", "cpu stop latency", n, 5, 12);
    window(16);
    chk("R2", "stopped lane released all window", int'(cpu_oe_low_all[0]), 1);
    chk("R2", "stopped lane true rises", cpu_rise[0], 0);
    chk("R4", "free cpu lane rises", cpu_rise[1], 4);
    chk("R4", "free cpu lane driven", int'(cpu_oe[1]), 1);
    @(negedge clk) cpu_stop_n = 1'b1;
    wait_oe(0, 1'b1, n);
    chk_rng("R3", "cpu release latency", n, 5, 12);
    window(16);
    chk("R3", "resumed cpu lane rises", cpu_rise[0], 4);
    @(negedge clk) begin cpu_stop_mask = 2'b11; cpu_stop_n = 1'b0; end
    idle(20);
    window(16);
    chk("R1", "both-stoppable lane0 rises", cpu_rise[0], 0);
    chk("R1", "both-stoppable lane1 rises", cpu_rise[1], 0);
    @(negedge clk) begin cpu_stop_n = 1'b1; cpu_stop_mask = 2'b01; end
    idle(20);
  endtask

  task automatic t_pci_stop();
    int n, fixed_rises;
    @(negedge clk) pci_stop_n = 1'b0;
    idle(30);
    window(16);
    chk("R5", "free bus lane0 (bit 0) rises", pci_rise[0], 2);
    chk("R5", "qualified bus lane1 (bit 1) rises", pci_rise[1], 0);
    fixed_rises = 0;
    for (int j = N_FREE; j < N_PCI; j++) fixed_rises += pci_rise[j];
    chk("R5", "fixed bus lanes rises", fixed_rises, 0);
    chk("R6", "stopped bus lanes park low", int'(pci_hi_seen[N_PCI-1:1]), 0);
    @(negedge clk) pci_stop_n = 1'b1;
    wait_pci_rise(2, n);
    chk_rng("R7", "bus release to first high phase", n, 9, 25);
    @(negedge clk) begin pci_free_stop = 2'b11; pci_stop_n = 1'b0; end
    idle(30);
    window(16);
    chk("R5", "bus lane0 with bit set rises", pci_rise[0], 0);
    @(negedge clk) begin pci_stop_n = 1'b1; pci_free_stop = 2'b10; end
    idle(30);
  endtask

  task automatic t_enable();
    @(negedge clk) begin pci_en[3] = 1'b0; cpu_en[1] = 1'b0; end
    idle(20);
    window(16);
    chk("R8", "disabled bus lane3 high seen", int'(pci_hi_seen[3]), 0);
    chk("R8", "disabled cpu lane1 released", int'(cpu_oe_low_all[1]), 1);
    chk("R8", "neighbour bus lane4 rises", pci_rise[4], 2);
    @(negedge clk) begin pci_free_stop = 2'b00; pci_stop_n = 1'b0; pci_en[0] = 1'b0; end
    idle(30);
    window(16);
    chk("R8", "disabled free lane0 under stop rises", pci_rise[0], 0);
    @(negedge clk) begin pci_stop_n = 1'b1; pci_en = '1; cpu_en = '1; pci_free_stop = 2'b10; end
    idle(30);
    window(16);
    chk("R8", "re-enabled bus lane3 rises", pci_rise[3], 2);
    chk("R8", "re-enabled cpu lane1 driven", int'(cpu_oe[1]), 1);
  endtask

  initial begin
    rst_n = 1'b0;
    cpu_stop_n = 1'b1;
    pci_stop_n = 1'b1;
    cpu_stop_mask = 2'b01;
    cpu_en = '1;
    pci_free_stop = 2'b10;
    pci_en = '1;
    t_reset();
    t_cpu_stop();
    t_pci_stop();
    t_enable();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
  end
endmodule